// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Field Stepping

The block keeps the time of day in six BCD digits: units and tens for each of seconds, minutes and hours. Hours run from 00 to 23. Every digit register sits on one system clock. A single-cycle 1 Hz tick pulse moves the count forward, and each field passes a carry to the next field up when it wraps. Enable pulses do the advancing, so no counter drives the clock of another.

A correction mode is provided for setting the time by hand. While correction is enabled, each rising edge of the UP strobe steps every selected field (hours, minutes, seconds) forward by one. A manual step wraps only inside its own field and carries nothing into the field above. The tick keeps counting while correction is enabled.

Top module: `tod_counter`

## Requirements
- R1: A synchronous active-high reset sets all six digits to zero on the next clock edge. Reset wins over a tick or a step in the same cycle.
- R2: The seconds units digit counts 0 to 9 on each tick. When it wraps from 9 to 0, the seconds tens digit increments.
- R3: The seconds tens digit counts 0 to 5. A tick at second 59 gives second 00 and increments the minutes field.
- R4: The minutes field counts 00 to 59 in the same way. A carry out of seconds at minute 59 gives minute 00 and increments the hours field.
- R5: The hours field counts 00 to 23. Its tens digit increments when the units digit wraps from 9, and a carry into hour 23 gives hour 00. A tick at 23:59:59 gives 00:00:00.
- R6: When correction is enabled and seconds is selected, a 0-to-1 transition of UP advances seconds by exactly one. Holding UP high gives no further step.
- R7: A manual step on minutes or hours advances that field by one with the same wrap (59 to 00, 23 to 00). A manual step never changes the next higher field.
- R8: With correction disabled, UP has no effect on any digit.
- R9: In a cycle with no tick, no carry and no step, every digit keeps its value.
- R10: The tick still advances seconds while correction is enabled. Steps on several selected fields in one cycle all take effect on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| corr_en | input | 1 | Enables manual correction |
| pick_hr | input | 1 | Selects hours for stepping |
| pick_min | input | 1 | Selects minutes for stepping |
| pick_sec | input | 1 | Selects seconds for stepping |
| up | input | 1 | Step strobe, acts on its rising edge |
| sec_ones | output | 4 | Seconds units, BCD |
| sec_tens | output | 3 | Seconds tens, 0..5 |
| min_ones | output | 4 | Minutes units, BCD |
| min_tens | output | 3 | Minutes tens, 0..5 |
| hr_ones | output | 4 | Hours units, BCD |
| hr_tens | output | 2 | Hours tens, 0..2 |

## Verification
The bench builds the block with its default parameters: a units limit of 9, a tens limit of 5 for seconds and minutes, and a tens limit of 2 with a final units digit of 3 for hours. These values keep the manual step path short. A few hundred cycles of stepping therefore reach 59 seconds, 59 minutes and hour 23. At those points the bench checks each wrap, the carry chain up to 23:59:59, and the absence of carry on manual steps.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int BCD_W     = 4;
    localparam int MS_TENS_W = 3;
    localparam int HR_TENS_W = 2;
endpackage

// File: rtl/tod_edge.sv
module tod_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic pulse_o
);
    logic seen_d, seen_q;

    always_comb begin
        seen_d  = lvl_i;
        pulse_o = lvl_i & ~seen_q;
    end

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= seen_d;
    end

    // R6: one rising edge gives one pulse
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/tod_pair.sv
module tod_pair #(
    parameter int UW         = 4,
    parameter int TW         = 3,
    parameter int UNITS_LAST = 9,
    parameter int TENS_LAST  = 5,
    parameter int WRAP_UNITS = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          auto_i,
    input  logic          man_i,
    output logic [UW-1:0] units_o,
    output logic [TW-1:0] tens_o,
    output logic          carry_o
);
    typedef struct packed {
        logic [UW-1:0] u;
        logic [TW-1:0] t;
    } pair_t;

    pair_t st_d, st_q;
    logic  adv, at_top, units_top;

    always_comb begin
        adv       = auto_i | man_i;
        units_top = (st_q.u == UW'(UNITS_LAST));
        at_top    = (st_q.t == TW'(TENS_LAST)) && (st_q.u == UW'(WRAP_UNITS));
        st_d      = st_q;
        if (adv) begin
            if (at_top) begin
                st_d.u = '0;
                st_d.t = '0;
            end else if (units_top) begin
                st_d.u = '0;
                st_d.t = st_q.t + 1'b1;
            end else begin
                st_d.u = st_q.u + 1'b1;
            end
        end
        carry_o = auto_i & at_top;
        units_o = st_q.u;
        tens_o  = st_q.t;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (units_o == '0) && (tens_o == '0));
    a_r2_units_range: assert property (@(posedge clk) disable iff (rst)
        units_o <= UW'(UNITS_LAST));
    a_r3_tens_range: assert property (@(posedge clk) disable iff (rst)
        tens_o <= TW'(TENS_LAST));
    a_r5_pair_limit: assert property (@(posedge clk) disable iff (rst)
        !((tens_o == TW'(TENS_LAST)) && (units_o > UW'(WRAP_UNITS))));
    a_r4_carry_wraps: assert property (@(posedge clk) disable iff (rst)
        carry_o |=> (units_o == '0) && (tens_o == '0));
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !(auto_i || man_i) |=> $stable(units_o) && $stable(tens_o));
endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_1hz,
    input  logic                 corr_en,
    input  logic                 pick_hr,
    input  logic                 pick_min,
    input  logic                 pick_sec,
    input  logic                 up,
    output logic [BCD_W-1:0]     sec_ones,
    output logic [MS_TENS_W-1:0] sec_tens,
    output logic [BCD_W-1:0]     min_ones,
    output logic [MS_TENS_W-1:0] min_tens,
    output logic [BCD_W-1:0]     hr_ones,
    output logic [HR_TENS_W-1:0] hr_tens
);
    logic up_pulse, step;
    logic sec_carry, min_carry, hr_carry;

    tod_edge i_edge (
        .clk(clk), .rst(rst), .lvl_i(up), .pulse_o(up_pulse)
    );

    always_comb step = up_pulse & corr_en;

    tod_pair #(.UW(BCD_W), .TW(MS_TENS_W), .UNITS_LAST(9), .TENS_LAST(5), .WRAP_UNITS(9)) i_sec (
        .clk(clk), .rst(rst), .auto_i(tick_1hz), .man_i(step & pick_sec),
        .units_o(sec_ones), .tens_o(sec_tens), .carry_o(sec_carry)
    );

    tod_pair #(.UW(BCD_W), .TW(MS_TENS_W), .UNITS_LAST(9), .TENS_LAST(5), .WRAP_UNITS(9)) i_min (
        .clk(clk), .rst(rst), .auto_i(sec_carry), .man_i(step & pick_min),
        .units_o(min_ones), .tens_o(min_tens), .carry_o(min_carry)
    );

    tod_pair #(.UW(BCD_W), .TW(HR_TENS_W), .UNITS_LAST(9), .TENS_LAST(2), .WRAP_UNITS(3)) i_hr (
        .clk(clk), .rst(rst), .auto_i(min_carry), .man_i(step & pick_hr),
        .units_o(hr_ones), .tens_o(hr_tens), .carry_o(hr_carry)
    );

    // R8: with correction off the minutes never move unless seconds carried
    a_r8_no_corr_min: assert property (@(posedge clk) disable iff (rst)
        (!corr_en && !sec_carry) |=> $stable(min_ones) && $stable(min_tens));
    // R7: the hour field has no higher field, so its carry must only come from minutes
    a_r7_hr_carry_src: assert property (@(posedge clk) disable iff (rst)
        hr_carry |-> min_carry);
endmodule

// File: tb/test_tod_counter.sv
module test_tod_counter;
    logic clk = 0, rst = 1, tick_1hz = 0, corr_en = 0;
    logic pick_hr = 0, pick_min = 0, pick_sec = 0, up = 0;
    logic [3:0] sec_ones, min_ones, hr_ones;
    logic [2:0] sec_tens, min_tens;
    logic [1:0] hr_tens;
    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tod_counter i_tod_counter (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .corr_en(corr_en),
        .pick_hr(pick_hr), .pick_min(pick_min), .pick_sec(pick_sec), .up(up),
        .sec_ones(sec_ones), .sec_tens(sec_tens), .min_ones(min_ones),
        .min_tens(min_tens), .hr_ones(hr_ones), .hr_tens(hr_tens)
    );

    function automatic logic [23:0] now();
        return {2'b0, hr_tens, hr_ones, 1'b0, min_tens, min_ones, 1'b0, sec_tens, sec_ones};
    endfunction

    task automatic chk(string req, logic [23:0] exp);
        checks++;
        if (now() !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, now(), exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    // vector: corr, pick_hr, pick_min, pick_sec, up, tick, expected hhmmss
    typedef struct packed {
        logic c, h, m, s, u, t;
        logic [23:0] exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 24'h000001},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 24'h000001},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 24'h000002},
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0, 24'h000003},
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0, 24'h000003},
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 24'h000003},
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 24'h000103},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 24'h000103},
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 24'h010103},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 24'h010103},
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 24'h010103},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 24'h010103},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1, 24'h010104},
        '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0, 24'h020205},
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 24'h020205}
    };
    localparam string VTAG [NV] = '{"R2","R9","R2","R6","R6","R6","R7","R7",
                                     "R7","R8","R8","R8","R10","R10","R10"};

    task automatic idle();
        corr_en = 0; pick_hr = 0; pick_min = 0; pick_sec = 0; up = 0; tick_1hz = 0;
    endtask

    task automatic do_reset();
        idle(); rst = 1; cyc(); rst = 0;
    endtask

    task automatic step(logic h, logic m, logic s, int n);
        for (int k = 0; k < n; k++) begin
            corr_en = 1; pick_hr = h; pick_min = m; pick_sec = s; up = 1; cyc();
            up = 0; cyc();
        end
        idle();
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) begin
            tick_1hz = 1; cyc();
        end
        tick_1hz = 0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
            finish_up();
        end
    end

    initial begin
        #1; cyc(); cyc(); rst = 0;
        chk("R1", 24'h000000);
        for (int i = 0; i < NV; i++) begin
            corr_en = VECS[i].c; pick_hr = VECS[i].h; pick_min = VECS[i].m;
            pick_sec = VECS[i].s; up = VECS[i].u; tick_1hz = VECS[i].t;
            cyc();
            chk(VTAG[i], VECS[i].exp);
        end
        idle(); cyc();

        // R1: reset beats a tick
        rst = 1; tick_1hz = 1; cyc(); rst = 0; tick_1hz = 0;
        chk("R1", 24'h000000);

        // R2: units wrap into tens
        ticks(9);  chk("R2", 24'h000009);
        ticks(1);  chk("R2", 24'h000010);

        // R3: second 59 tick carries into minutes
        do_reset(); step(0, 0, 1, 59); chk("R6", 24'h000059);
        ticks(1);  chk("R3", 24'h000100);

        // R4: minute 59 carry into hours
        step(0, 1, 0, 58); step(0, 0, 1, 59); chk("R4", 24'h005959);
        ticks(1);  chk("R4", 24'h010000);

        // R7: manual seconds wrap without carry
        step(0, 0, 1, 59); step(0, 0, 1, 1); chk("R7", 24'h010000);

        // R5: hour tens advance and midnight rollover
        do_reset(); step(1, 0, 0, 9); chk("R5", 24'h090000);
        step(1, 0, 0, 1); chk("R5", 24'h100000);
        step(1, 0, 0, 13); step(0, 1, 0, 59); step(0, 0, 1, 59);
        chk("R5", 24'h235959);
        ticks(1);  chk("R5", 24'h000000);

        // R7: manual hour 23 -> 00, manual minute 59 -> 00 with hour unchanged
        step(1, 0, 0, 23); chk("R7", 24'h230000);
        step(1, 0, 0, 1);  chk("R7", 24'h000000);
        step(0, 1, 0, 59); step(0, 1, 0, 1); chk("R7", 24'h000000);

        // R8: UP toggles with correction off
        step(0, 0, 0, 1);
        pick_sec = 1; up = 1; cyc(); up = 0; cyc(); idle();
        chk("R8", 24'h000000);

        // R9: long idle holds
        step(0, 0, 1, 7);
        for (int k = 0; k < 20; k++) cyc();
        chk("R9", 24'h000007);

        finish_up();
    end
endmodule